// File: doc/BRIEF.md
# External Bus Zone Controller

This block sits between a CPU memory bus and the chip's external memory pins. Each CPU request that is not an I/O access is decoded by the top four address bits into one of five external zones. The block then drives that zone's active-low chip-select pin together with an active-low read or write strobe. The strobe stays low for the zone's programmed wait states. It can then be stretched further by an external ready input. When the strobe ends, the block returns a one-cycle acknowledge to the CPU. Three chip-select pins serve the five zones: zones 0 and 1 share the low pin, zone 2 has the middle pin alone, and zones 6 and 7 share the high pin.

A boot-mode bit picks what answers the top address region (region code 0xF), which holds the reset vectors. With the bit set, zone 7 answers there and vectors are fetched from outside the chip. With the bit clear, zone 7 is off and the block raises a boot-ROM select so that on-chip ROM serves the region. The bit is loaded from a strap pin while reset is held. Software can rewrite it later.

The controller runs a four-state machine:
- IDLE: waits for a request that hits a zone.
- WAIT: strobe asserted, counting down the wait states.
- RDY: strobe still asserted, waiting for ready high.
- ACK: strobes released, acknowledge pulsed, read data presented.

Its transitions are:
- IDLE→WAIT: a decoded hit.
- WAIT→WAIT: the count is not yet zero.
- WAIT→RDY: the count is zero, ready sampling is on, and ready is low.
- WAIT→ACK: the count is zero and either ready sampling is off or ready is high.
- RDY→ACK: ready is high.
- ACK→IDLE: always.

Top module: `zbus_top`

## Requirements
- R1: The region code is address bits [ADDR_W-1:ADDR_W-4]. Code 0x0 selects zone 0 and code 0x1 selects zone 1, both on `ecs_lo_n`. Code 0x8 selects zone 2 on `ecs_mid_n`. Code 0xA selects zone 6 on `ecs_hi_n`. Code 0xF selects zone 7 on `ecs_hi_n`, but only when the mode bit is 1. Any other code gets no chip select and no acknowledge.
- R2: Chip selects and strobes are active low. At most one chip select is low at a time, and none is low while the controller is idle or after reset.
- R3: A zone with wait count W and ready sampling off holds its chip select and strobe low for exactly W+1 cycles. `cpu_ack` is then high for exactly one cycle, with the chip select released.
- R4: For a zone with ready sampling on, suppose ready first goes high K cycles into the strobe. The strobe then lasts max(W+1, K) cycles before the acknowledge.
- R5: For a zone with ready sampling off, the level of `ext_ready` has no effect on the strobe length.
- R6: After reset every zone has W=15 and ready sampling off, so an unconfigured access strobes for 16 cycles.
- R7: The mode bit takes the level of `boot_mode_i` sampled while `rst_n` is low.
- R8: While the mode bit is 0, a memory request to region 0xF raises `rom_sel` combinationally and drives no chip select or acknowledge. `rom_sel` is 0 whenever the mode bit is 1.
- R9: A write with `cfg_mode_we` high replaces the mode bit with `cfg_mode`, taking effect from the next cycle.
- R10: The mode bit changes only the region 0xF mapping. A zone 6 access behaves the same with the mode bit at 0 or at 1.
- R11: A request with `cpu_io` high is never decoded: no chip select, no acknowledge, no `rom_sel`.
- R12: A read drives `ext_rd_n` low and returns `ext_rdata`, sampled on the last strobe cycle, on `cpu_rdata` in the acknowledge cycle. A write drives `ext_wr_n` low with `cpu_wdata` on `ext_wdata`. The two strobes are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| boot_mode_i | input | 1 | Boot strap pin, sampled during reset |
| cpu_req | input | 1 | Request, held until acknowledge |
| cpu_io | input | 1 | Request targets I/O space |
| cpu_wr | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Write data |
| cpu_rdata | output | DATA_W | Read data, valid with acknowledge |
| cpu_ack | output | 1 | One-cycle completion pulse |
| cfg_we | input | 1 | Zone configuration write enable |
| cfg_zone | input | 3 | Zone slot: 0=z0, 1=z1, 2=z2, 3=z6, 4=z7 |
| cfg_wait | input | 4 | Wait-state count to store |
| cfg_use_rdy | input | 1 | Ready-sampling enable to store |
| cfg_mode_we | input | 1 | Mode bit write enable |
| cfg_mode | input | 1 | New mode bit value |
| ecs_lo_n | output | 1 | Chip select, zones 0 and 1 |
| ecs_mid_n | output | 1 | Chip select, zone 2 |
| ecs_hi_n | output | 1 | Chip select, zones 6 and 7 |
| ext_rd_n | output | 1 | Read strobe |
| ext_wr_n | output | 1 | Write strobe |
| ext_addr | output | ADDR_W | Latched access address |
| ext_wdata | output | DATA_W | Latched write data |
| ext_rdata | input | DATA_W | External read data |
| ext_ready | input | 1 | External ready |
| rom_sel | output | 1 | Boot ROM select for region 0xF |

## Verification
The bench runs the ready input against the wait counter from both sides. In one case ready arrives long after the count ends. In the other it arrives before the count ends. A design that counted the two together instead of taking the later one would report the wrong strobe length. It also holds ready low on a zone with sampling off; a controller that consulted ready anyway would hang and trip the watchdog. Region 0xF is probed across two resets with opposite strap levels and across software rewrites of the mode bit. Zone 6 is accessed in both modes, so a mode bit that leaked into other regions, or a strap that was not latched, shows up as a wrong chip select or a missing `rom_sel`. I/O and unmapped probes catch a decoder that ignores the space flag or aliases codes.

// File: rtl/zbus_pkg.sv
package zbus_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT,
        ST_RDY,
        ST_ACK
    } zb_state_e;

    localparam int NUM_ZONES = 5;
    localparam int NUM_CS    = 3;
    localparam int WS_W      = 4;
    localparam int SLOT_W    = 3;
    localparam int REG_W     = 4;

    // slot 4 (zone 7) is the boot-region zone
    localparam int BOOT_SLOT = 4;
    localparam logic [REG_W-1:0] BOOT_REGION = 4'hF;

    typedef struct packed {
        logic            use_rdy;
        logic [WS_W-1:0] wait_cnt;
    } zone_cfg_t;

    function automatic logic [REG_W-1:0] slot_region(input int slot);
        case (slot)
            0:       return 4'h0;
            1:       return 4'h1;
            2:       return 4'h8;
            3:       return 4'hA;
            default: return BOOT_REGION;
        endcase
    endfunction

    // chip-select pin index: 0 = low pin, 1 = mid pin, 2 = high pin
    function automatic int cs_group(input logic [SLOT_W-1:0] slot);
        case (slot)
            3'd0, 3'd1: return 0;
            3'd2:       return 1;
            default:    return 2;
        endcase
    endfunction

endpackage

// File: rtl/zbus_decode.sv
module zbus_decode
    import zbus_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              io_space,
    input  logic              mode,
    output logic              hit,
    output logic [SLOT_W-1:0] slot,
    output logic              boot_region
);
    localparam int REG_LSB = ADDR_W - REG_W;

    logic [REG_W-1:0]     region;
    logic [NUM_ZONES-1:0] match;

    assign region      = addr[ADDR_W-1:REG_LSB];
    assign boot_region = !io_space && (region == BOOT_REGION);

    for (genvar z = 0; z < NUM_ZONES; z++) begin : g_match
        if (z == BOOT_SLOT) begin : g_boot
            assign match[z] = !io_space && mode && (region == slot_region(z));
        end else begin : g_plain
            assign match[z] = !io_space && (region == slot_region(z));
        end
    end

    always_comb begin
        hit  = 1'b0;
        slot = '0;
        for (int z = 0; z < NUM_ZONES; z++) begin
            if (match[z]) begin
                hit  = 1'b1;
                slot = SLOT_W'(z);
            end
        end
    end

endmodule

// File: rtl/zbus_cfg.sv
module zbus_cfg
    import zbus_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              boot_mode_i,
    input  logic              cfg_we,
    input  logic [SLOT_W-1:0] cfg_zone,
    input  logic [WS_W-1:0]   cfg_wait,
    input  logic              cfg_use_rdy,
    input  logic              cfg_mode_we,
    input  logic              cfg_mode,
    output zone_cfg_t         zcfg [NUM_ZONES],
    output logic              mode
);
    for (genvar z = 0; z < NUM_ZONES; z++) begin : g_zone
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                zcfg[z].wait_cnt <= '1;
                zcfg[z].use_rdy  <= 1'b0;
            end else if (cfg_we && cfg_zone == SLOT_W'(z)) begin
                zcfg[z].wait_cnt <= cfg_wait;
                zcfg[z].use_rdy  <= cfg_use_rdy;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode <= boot_mode_i;
        end else if (cfg_mode_we) begin
            mode <= cfg_mode;
        end
    end

endmodule

// File: rtl/zbus_top.sv
module zbus_top
    import zbus_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              boot_mode_i,
    input  logic              cpu_req,
    input  logic              cpu_io,
    input  logic              cpu_wr,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_ack,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_zone,
    input  logic [3:0]        cfg_wait,
    input  logic              cfg_use_rdy,
    input  logic              cfg_mode_we,
    input  logic              cfg_mode,
    output logic              ecs_lo_n,
    output logic              ecs_mid_n,
    output logic              ecs_hi_n,
    output logic              ext_rd_n,
    output logic              ext_wr_n,
    output logic [ADDR_W-1:0] ext_addr,
    output logic [DATA_W-1:0] ext_wdata,
    input  logic [DATA_W-1:0] ext_rdata,
    input  logic              ext_ready,
    output logic              rom_sel
);
    zb_state_e         state_q;
    logic [WS_W-1:0]   cnt_q;
    logic [SLOT_W-1:0] slot_q;
    logic              wr_q;
    logic              rdy_en_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;

    zone_cfg_t         zcfg [NUM_ZONES];
    zone_cfg_t         sel_cfg;
    logic              mode;
    logic              hit;
    logic              boot_region;
    logic [SLOT_W-1:0] slot;
    logic [NUM_CS-1:0] cs_n;
    logic              strobe;

    zbus_cfg u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .boot_mode_i (boot_mode_i),
        .cfg_we      (cfg_we),
        .cfg_zone    (cfg_zone),
        .cfg_wait    (cfg_wait),
        .cfg_use_rdy (cfg_use_rdy),
        .cfg_mode_we (cfg_mode_we),
        .cfg_mode    (cfg_mode),
        .zcfg        (zcfg),
        .mode        (mode)
    );

    zbus_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr        (cpu_addr),
        .io_space    (cpu_io),
        .mode        (mode),
        .hit         (hit),
        .slot        (slot),
        .boot_region (boot_region)
    );

    always_comb begin
        sel_cfg = zcfg[0];
        for (int z = 0; z < NUM_ZONES; z++) begin
            if (slot == SLOT_W'(z)) sel_cfg = zcfg[z];
        end
    end

    // state register and access context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            cnt_q    <= '0;
            slot_q   <= '0;
            wr_q     <= 1'b0;
            rdy_en_q <= 1'b0;
            addr_q   <= '0;
            wdata_q  <= '0;
            rdata_q  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (cpu_req && hit) begin
                        state_q  <= ST_WAIT;
                        cnt_q    <= sel_cfg.wait_cnt;
                        rdy_en_q <= sel_cfg.use_rdy;
                        slot_q   <= slot;
                        wr_q     <= cpu_wr;
                        addr_q   <= cpu_addr;
                        wdata_q  <= cpu_wdata;
                    end
                end
                ST_WAIT: begin
                    if (cnt_q != '0) begin
                        cnt_q <= cnt_q - 1'b1;
                    end else if (rdy_en_q && !ext_ready) begin
                        state_q <= ST_RDY;
                    end else begin
                        state_q <= ST_ACK;
                        rdata_q <= ext_rdata;
                    end
                end
                ST_RDY: begin
                    if (ext_ready) begin
                        state_q <= ST_ACK;
                        rdata_q <= ext_rdata;
                    end
                end
                ST_ACK: begin
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        strobe = (state_q == ST_WAIT) || (state_q == ST_RDY);
        cs_n   = '1;
        if (strobe) cs_n[cs_group(slot_q)] = 1'b0;
        ecs_lo_n  = cs_n[0];
        ecs_mid_n = cs_n[1];
        ecs_hi_n  = cs_n[2];
        ext_rd_n  = !(strobe && !wr_q);
        ext_wr_n  = !(strobe && wr_q);
        ext_addr  = addr_q;
        ext_wdata = wdata_q;
        cpu_ack   = (state_q == ST_ACK);
        cpu_rdata = rdata_q;
        rom_sel   = cpu_req && boot_region && !mode;
    end

endmodule

// File: rtl/zbus_chk.sv
module zbus_chk
    import zbus_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      cpu_req,
    input logic      cpu_io,
    input logic      cpu_ack,
    input logic      ecs_lo_n,
    input logic      ecs_mid_n,
    input logic      ecs_hi_n,
    input logic      ext_rd_n,
    input logic      ext_wr_n,
    input logic      ext_ready,
    input logic      rom_sel,
    input zb_state_e state_q
);
    logic [2:0] cs_low;
    assign cs_low = {!ecs_hi_n, !ecs_mid_n, !ecs_lo_n};

    // R2
    one_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(cs_low) <= 1);

    // R2
    idle_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> (cs_low == 3'b000));

    // R3
    ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ack |=> !cpu_ack);

    // R3
    ack_after_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_ack) |-> ($past(cs_low) != 3'b000 && cs_low == 3'b000));

    // R4
    rdy_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RDY && ext_ready) |=> cpu_ack);

    // R8
    rom_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rom_sel && state_q == ST_IDLE) |=> (cs_low == 3'b000));

    // R11
    io_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && cpu_req && cpu_io) |=> (state_q == ST_IDLE && !rom_sel));

    // R12
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!ext_rd_n && !ext_wr_n));

    // R12
    strobe_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_rd_n || !ext_wr_n) |-> (cs_low != 3'b000));

endmodule

bind zbus_top zbus_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_req   (cpu_req),
    .cpu_io    (cpu_io),
    .cpu_ack   (cpu_ack),
    .ecs_lo_n  (ecs_lo_n),
    .ecs_mid_n (ecs_mid_n),
    .ecs_hi_n  (ecs_hi_n),
    .ext_rd_n  (ext_rd_n),
    .ext_wr_n  (ext_wr_n),
    .ext_ready (ext_ready),
    .rom_sel   (rom_sel),
    .state_q   (state_q)
);

// File: tb/test_zbus_top.sv
module test_zbus_top;
    localparam int ADDR_W = 20;
    localparam int DATA_W = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              boot_mode_i = 1'b0;
    logic              cpu_req = 1'b0;
    logic              cpu_io = 1'b0;
    logic              cpu_wr = 1'b0;
    logic [ADDR_W-1:0] cpu_addr = '0;
    logic [DATA_W-1:0] cpu_wdata = '0;
    logic [DATA_W-1:0] cpu_rdata;
    logic              cpu_ack;
    logic              cfg_we = 1'b0;
    logic [2:0]        cfg_zone = '0;
    logic [3:0]        cfg_wait = '0;
    logic              cfg_use_rdy = 1'b0;
    logic              cfg_mode_we = 1'b0;
    logic              cfg_mode = 1'b0;
    logic              ecs_lo_n, ecs_mid_n, ecs_hi_n;
    logic              ext_rd_n, ext_wr_n;
    logic [ADDR_W-1:0] ext_addr;
    logic [DATA_W-1:0] ext_wdata;
    logic [DATA_W-1:0] ext_rdata = '0;
    logic              ext_ready = 1'b0;
    logic              rom_sel;

    zbus_top #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_zbus_top (.*);

    always #2 clk = !clk;

    typedef struct {
        int              grp;
        int              len;
        bit              wr;
        logic [DATA_W-1:0] data;
        string           tag;
    } exp_t;

    exp_t sb[$];
    int   n_chk = 0;
    int   n_bad = 0;
    int   cyc = 0;
    int   rdy_k = 0;
    int   rdy_cnt = 0;
    int   mon_len = 0;
    int   mon_grp = -1;
    bit   mon_wr = 0;
    logic [DATA_W-1:0] mon_wd = '0;
    logic [2:0] cs_low;

    assign cs_low = {!ecs_hi_n, !ecs_mid_n, !ecs_lo_n};

    task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
        end
    endtask

    function automatic int grp_of(input logic [2:0] v);
        if (v == 3'b001) return 0;
        if (v == 3'b010) return 1;
        if (v == 3'b100) return 2;
        return -1;
    endfunction

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 20000);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    // ready model: ready rises K strobe cycles into the access (K=0: never)
    always @(negedge clk) begin
        if (cs_low != 3'b000) begin
            rdy_cnt = rdy_cnt + 1;
            if (rdy_k > 0 && rdy_cnt == rdy_k) ext_ready = 1'b1;
        end else begin
            rdy_cnt   = 0;
            ext_ready = 1'b0;
        end
    end

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (cs_low != 3'b000) begin
                mon_len++;
                mon_grp = grp_of(cs_low);
                mon_wr  = !ext_wr_n;
                mon_wd  = ext_wdata;
            end
            if (cpu_ack) begin
                if (sb.size() == 0) begin
                    chk(0, "R1 unexpected ack", 1, 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    chk(mon_grp == e.grp, {e.tag, " chip select"}, mon_grp, e.grp);
                    chk(mon_len == e.len, {e.tag, " strobe length"}, mon_len, e.len);
                    chk(cs_low == 3'b000, {e.tag, " cs released at ack"}, cs_low, 0);
                    if (e.wr) begin
                        chk(mon_wr, "R12 write strobe", mon_wr, 1);
                        chk(mon_wd == e.data, "R12 write data", mon_wd, e.data);
                    end else begin
                        chk(!mon_wr, "R12 read strobe", mon_wr, 0);
                        chk(cpu_rdata == e.data, "R12 read data", cpu_rdata, e.data);
                    end
                end
                mon_len = 0;
                mon_grp = -1;
            end
        end
    end

    task automatic do_reset(input bit pin);
        @(negedge clk);
        rst_n       = 1'b0;
        boot_mode_i = pin;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        boot_mode_i = !pin;
    endtask

    task automatic set_zone(input int slot, input int w, input bit r);
        @(negedge clk);
        cfg_we      = 1'b1;
        cfg_zone    = 3'(slot);
        cfg_wait    = 4'(w);
        cfg_use_rdy = r;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic set_mode(input bit m);
        @(negedge clk);
        cfg_mode_we = 1'b1;
        cfg_mode    = m;
        @(negedge clk);
        cfg_mode_we = 1'b0;
    endtask

    task automatic access(input logic [3:0] region, input bit wr, input logic [DATA_W-1:0] d,
                          input int grp, input int len, input int k, input string tag);
        exp_t e;
        e.grp = grp; e.len = len; e.wr = wr; e.data = d; e.tag = tag;
        sb.push_back(e);
        @(negedge clk);
        rdy_k     = k;
        ext_rdata = d;
        cpu_addr  = {region, 16'h0123};
        cpu_wr    = wr;
        cpu_wdata = d;
        cpu_io    = 1'b0;
        cpu_req   = 1'b1;
        do @(negedge clk); while (!cpu_ack);
        cpu_req = 1'b0;
        rdy_k   = 0;
    endtask

    task automatic probe_none(input logic [3:0] region, input bit io, input bit exp_rom, input string tag);
        @(negedge clk);
        cpu_addr = {region, 16'h0040};
        cpu_io   = io;
        cpu_wr   = 1'b0;
        cpu_req  = 1'b1;
        #1;
        chk(rom_sel == exp_rom, {tag, " rom_sel"}, rom_sel, exp_rom);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(cs_low == 3'b000 && !cpu_ack, {tag, " no response"}, {cs_low, cpu_ack}, 0);
        end
        cpu_req = 1'b0;
        cpu_io  = 1'b0;
    endtask

    initial begin
        do_reset(1'b0);
        @(negedge clk);
        // R2 reset state
        chk(cs_low == 3'b000 && ext_rd_n && ext_wr_n && !cpu_ack, "R2 reset idle pins",
            {cs_low, ext_rd_n, ext_wr_n, cpu_ack}, 6);
        // R6 unconfigured zone 0
        access(4'h0, 1'b0, 16'hA5A5, 0, 16, 0, "R6 default wait");
        // configure: z0 W2, z1 W0, z2 W5 ready, z6 W3, z7 W1
        set_zone(0, 2, 1'b0);
        set_zone(1, 0, 1'b0);
        set_zone(2, 5, 1'b1);
        set_zone(3, 3, 1'b0);
        set_zone(4, 1, 1'b0);
        access(4'h0, 1'b1, 16'hBEEF, 0, 3, 0, "R3 zone0 write");
        access(4'h1, 1'b0, 16'h1111, 0, 1, 0, "R1 zone1 shared pin");
        access(4'h8, 1'b0, 16'h2222, 1, 9, 9, "R4 late ready");
        access(4'h8, 1'b1, 16'h3333, 1, 6, 2, "R4 early ready");
        access(4'hA, 1'b1, 16'h6666, 2, 4, 0, "R1 zone6");
        access(4'h0, 1'b0, 16'h0F0F, 0, 3, 0, "R5 ready ignored");
        access(4'h0, 1'b0, 16'hF0F0, 0, 3, 1, "R5 ready high ignored");
        probe_none(4'hF, 1'b0, 1'b1, "R8 boot rom");
        probe_none(4'h5, 1'b0, 1'b0, "R1 unmapped");
        probe_none(4'h0, 1'b1, 1'b0, "R11 io space");
        set_mode(1'b1);
        access(4'hF, 1'b0, 16'h7777, 2, 2, 0, "R9 zone7 mapped");
        access(4'hA, 1'b0, 16'h6A6A, 2, 4, 0, "R10 zone6 mode1");
        set_mode(1'b0);
        probe_none(4'hF, 1'b0, 1'b1, "R9 rom back");
        access(4'hA, 1'b0, 16'h6B6B, 2, 4, 0, "R10 zone6 mode0");
        do_reset(1'b1);
        access(4'hF, 1'b0, 16'h7A7A, 2, 16, 0, "R7 strap high");
        do_reset(1'b0);
        probe_none(4'hF, 1'b0, 1'b1, "R7 strap low");
        repeat (3) @(negedge clk);
        chk(sb.size() == 0, "R3 all accesses acknowledged", sb.size(), 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule